// File: doc/BRIEF.md
# OLED Panel Command Sequencer

This block feeds command bytes to a monochrome OLED panel controller over a write-only byte link with a data/command select line. When reset is released it waits a programmable number of clock cycles. It then walks a fixed power-up command list, and the list contents depend on the panel's row count (64, 48 or 32). Every opcode and every argument goes out as its own byte, with the select line held at the command level. Each byte is held on a valid/ready output until the downstream serialiser accepts it.

After power-up the block serves four runtime requests: blank the panel, unblank it, load an 8-bit contrast value, and reset the addressing window. A request that arrives while the power-up list or another request is still going out is latched. It is served once the block becomes idle. The serial shift register and the pixel data stream sit outside this block.

Top module: `oled_cmd_seq`

## Requirements
- R1: `dc` is 0 for every byte accepted, and each accepted byte costs exactly one `byte_valid`/`byte_ready` handshake.
- R2: While `byte_valid` is 1 and `byte_ready` is 0, in the next cycle `byte_valid` stays 1 and `byte_out` is unchanged.
- R3: The power-up list is the 25 bytes AE, D5, 80, A8, m, D3, 00, 40, 8D, 14, 20, 01, A1, C8, DA, p, D9, F1, DB, 40, A4, A6, 81, c, AF (hex). Here m is 3F for 64 rows, 2F for 48 rows and 1F otherwise, and p is 12 for 64 or 48 rows and 02 otherwise.
- R4: `busy` is 1 from reset until the final power-up byte (AF) is accepted. It drops in the cycle after that handshake and then stays 0.
- R5: The contrast byte c in the power-up list is the parameter `CONTRAST` when that is non-zero. Otherwise it is CF for 64 rows and 8F for any other height.
- R6: After `rst_n` rises, `byte_valid` first goes to 1 exactly `RST_HOLD` clock cycles later.
- R7: A blank request sends AE and an unblank request sends AF. A later one of the two cancels a pending earlier one. When both arrive in the same cycle, blank wins.
- R8: A contrast request sends 81 followed by the value on `contrast_val`. If several contrast requests arrive before the sequence starts, the value from the last one is used.
- R9: A window request sends 00, 10, 40. When the panel is 64 columns by 48 rows, it then also sends 21, 20, 5F, 22, 00, 05.
- R10: Requests that arrive while a sequence is running are held. They are served after the running sequence in the fixed order blank/unblank, contrast, window, with at least one idle cycle between sequences.
- R11: While `rst_n` is 0, `byte_valid` is 0, `busy` is 1 and `dc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_req | input | 1 | One-cycle request to turn the panel off |
| unblank_req | input | 1 | One-cycle request to turn the panel on |
| contrast_req | input | 1 | One-cycle request to load a contrast value |
| contrast_val | input | 8 | Contrast value, sampled with `contrast_req` |
| window_req | input | 1 | One-cycle request to reset the addressing window |
| byte_ready | input | 1 | Downstream accepts `byte_out` this cycle |
| byte_valid | output | 1 | `byte_out` holds a byte to send |
| byte_out | output | 8 | Command or argument byte |
| dc | output | 1 | Data/command select, 0 means command |
| busy | output | 1 | Power-up list still in progress |

## Verification
The stall property assumes that `byte_ready` can be any value in any cycle, even while `byte_valid` is low. The bench therefore drives ready in a fixed two-of-three pattern that produces a stall on almost every sequence. The request inputs are taken to be one-cycle pulses driven between clock edges. `contrast_val` only needs to be meaningful in the cycle of `contrast_req`, so the bench changes it with each pulse. The bench fires requests both during the power-up list and on top of a running window sequence, so that the pending-request cancellation and ordering rules come into play.

// File: rtl/oled_cmd_seq.sv
module oled_cmd_seq #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  parameter int RST_HOLD = 16,
  parameter logic [7:0] CONTRAST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blank_req,
  input  logic       unblank_req,
  input  logic       contrast_req,
  input  logic [7:0] contrast_val,
  input  logic       window_req,
  input  logic       byte_ready,
  output logic       byte_valid,
  output logic [7:0] byte_out,
  output logic       dc,
  output logic       busy
);
  localparam logic [7:0] MUX_ARG = (ROWS == 64) ? 8'h3F : (ROWS == 48) ? 8'h2F : 8'h1F;
  localparam logic [7:0] PIN_ARG = (ROWS == 64 || ROWS == 48) ? 8'h12 : 8'h02;
  localparam logic [7:0] CTR_DEF = (CONTRAST != 8'h00) ? CONTRAST : (ROWS == 64) ? 8'hCF : 8'h8F;
  localparam bit SMALL_WIN = (COLS == 64) && (ROWS == 48);
  localparam int INIT_LEN = 25;
  localparam int WIN_LEN = SMALL_WIN ? 9 : 3;
  localparam int IW = $clog2(INIT_LEN);
  localparam int HW = $clog2(RST_HOLD + 1);

  typedef enum logic [1:0] {ST_HOLD, ST_IDLE, ST_SEND} state_t;
  typedef enum logic [2:0] {OP_INIT, OP_OFF, OP_ON, OP_CTR, OP_WIN} op_t;

  state_t state;
  op_t op;
  logic [IW-1:0] idx, last;
  logic [HW-1:0] hold_cnt;
  logic pend_off, pend_on, pend_ctr, pend_win, init_due;
  logic [7:0] ctr_val, arg, rom;
  logic fire, pick;

  assign byte_valid = (state == ST_SEND);
  assign fire = byte_valid && byte_ready;
  assign pick = (state == ST_IDLE) && (pend_off || pend_on || pend_ctr || pend_win);
  assign byte_out = rom;
  assign dc = 1'b0;
  assign busy = init_due;

  always_comb begin
    case (op)
      OP_INIT: last = IW'(INIT_LEN - 1);
      OP_CTR:  last = IW'(1);
      OP_WIN:  last = IW'(WIN_LEN - 1);
      default: last = '0;
    endcase
  end

  always_comb begin
    rom = 8'h00;
    case (op)
      OP_INIT:
        case (idx)
          5'd0:  rom = 8'hAE;
          5'd1:  rom = 8'hD5;
          5'd2:  rom = 8'h80;
          5'd3:  rom = 8'hA8;
          5'd4:  rom = MUX_ARG;
          5'd5:  rom = 8'hD3;
          5'd6:  rom = 8'h00;
          5'd7:  rom = 8'h40;
          5'd8:  rom = 8'h8D;
          5'd9:  rom = 8'h14;
          5'd10: rom = 8'h20;
          5'd11: rom = 8'h01;
          5'd12: rom = 8'hA1;
          5'd13: rom = 8'hC8;
          5'd14: rom = 8'hDA;
          5'd15: rom = PIN_ARG;
          5'd16: rom = 8'hD9;
          5'd17: rom = 8'hF1;
          5'd18: rom = 8'hDB;
          5'd19: rom = 8'h40;
          5'd20: rom = 8'hA4;
          5'd21: rom = 8'hA6;
          5'd22: rom = 8'h81;
          5'd23: rom = CTR_DEF;
          5'd24: rom = 8'hAF;
          default: rom = 8'h00;
        endcase
      OP_OFF: rom = 8'hAE;
      OP_ON:  rom = 8'hAF;
      OP_CTR: rom = (idx == '0) ? 8'h81 : arg;
      OP_WIN:
        case (idx)
          5'd0: rom = 8'h00;
          5'd1: rom = 8'h10;
          5'd2: rom = 8'h40;
          5'd3: rom = 8'h21;
          5'd4: rom = 8'h20;
          5'd5: rom = 8'h5F;
          5'd6: rom = 8'h22;
          5'd7: rom = 8'h00;
          5'd8: rom = 8'h05;
          default: rom = 8'h00;
        endcase
      default: rom = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      op       <= OP_INIT;
      idx      <= '0;
      hold_cnt <= '0;
      init_due <= 1'b1;
      arg      <= 8'h00;
    end else begin
      case (state)
        ST_HOLD:
          if (hold_cnt == HW'(RST_HOLD - 1)) state <= ST_SEND;
          else hold_cnt <= hold_cnt + 1'b1;
        ST_IDLE:
          if (pend_off) begin
            op <= OP_OFF; state <= ST_SEND;
          end else if (pend_on) begin
            op <= OP_ON; state <= ST_SEND;
          end else if (pend_ctr) begin
            op <= OP_CTR; arg <= ctr_val; state <= ST_SEND;
          end else if (pend_win) begin
            op <= OP_WIN; state <= ST_SEND;
          end
        ST_SEND:
          if (fire) begin
            if (idx == last) begin
              idx <= '0;
              state <= ST_IDLE;
              if (op == OP_INIT) init_due <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
      pend_ctr <= 1'b0;
      pend_win <= 1'b0;
      ctr_val  <= 8'h00;
    end else begin
      if (pick) begin
        if (pend_off) pend_off <= 1'b0;
        else if (pend_on) pend_on <= 1'b0;
        else if (pend_ctr) pend_ctr <= 1'b0;
        else pend_win <= 1'b0;
      end
      if (unblank_req) begin
        pend_on <= 1'b1; pend_off <= 1'b0;
      end
      if (blank_req) begin
        pend_off <= 1'b1; pend_on <= 1'b0;
      end
      if (contrast_req) begin
        pend_ctr <= 1'b1; ctr_val <= contrast_val;
      end
      if (window_req) pend_win <= 1'b1;
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_out));

  p_init_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) && busy |-> byte_out == 8'hAE);

  p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fire) && $past(byte_out) == 8'hAF);

  p_busy_stays_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  p_blank_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_off && pend_on));
endmodule

// File: tb/oled_cmd_seq_bench.sv
`timescale 1ns/1ps
module oled_cmd_seq_bench;
  localparam int HOLD = 5;
  localparam int ROWS_C [3] = '{64, 48, 32};
  localparam int COLS_C [3] = '{128, 64, 128};
  localparam logic [7:0] CTR_C [3] = '{8'h00, 8'h00, 8'h3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic blank_req = 0, unblank_req = 0, contrast_req = 0, window_req = 0, rdy = 0;
  logic [7:0] cval = 8'h00;
  logic vld [3];
  logic [7:0] bo [3];
  logic dcv [3];
  logic bsy [3];

  oled_cmd_seq #(.ROWS(ROWS_C[0]), .COLS(COLS_C[0]), .RST_HOLD(HOLD), .CONTRAST(CTR_C[0])) u_oled_cmd_seq (
    .clk(clk), .rst_n(rst_n), .blank_req(blank_req), .unblank_req(unblank_req),
    .contrast_req(contrast_req), .contrast_val(cval), .window_req(window_req),
    .byte_ready(rdy), .byte_valid(vld[0]), .byte_out(bo[0]), .dc(dcv[0]), .busy(bsy[0]));
  oled_cmd_seq #(.ROWS(ROWS_C[1]), .COLS(COLS_C[1]), .RST_HOLD(HOLD), .CONTRAST(CTR_C[1])) u_oled_cmd_seq_b (
    .clk(clk), .rst_n(rst_n), .blank_req(blank_req), .unblank_req(unblank_req),
    .contrast_req(contrast_req), .contrast_val(cval), .window_req(window_req),
    .byte_ready(rdy), .byte_valid(vld[1]), .byte_out(bo[1]), .dc(dcv[1]), .busy(bsy[1]));
  oled_cmd_seq #(.ROWS(ROWS_C[2]), .COLS(COLS_C[2]), .RST_HOLD(HOLD), .CONTRAST(CTR_C[2])) u_oled_cmd_seq_c (
    .clk(clk), .rst_n(rst_n), .blank_req(blank_req), .unblank_req(unblank_req),
    .contrast_req(contrast_req), .contrast_val(cval), .window_req(window_req),
    .byte_ready(rdy), .byte_valid(vld[2]), .byte_out(bo[2]), .dc(dcv[2]), .busy(bsy[2]));

  int n_tests = 0, n_fail = 0, cyc = 0, quiet = 0;
  logic [7:0] got [3][0:255];
  logic [7:0] expb [3][0:255];
  int ngot [3] = '{0, 0, 0};
  int nexp [3] = '{0, 0, 0};
  int pos [3] = '{0, 0, 0};
  logic stall_prev [3] = '{0, 0, 0};
  logic [7:0] byte_prev [3];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    bit any;
    cyc++;
    any = 0;
    if (rst_n) begin
      for (int d = 0; d < 3; d++)
        if (stall_prev[d]) chk(vld[d] && bo[d] == byte_prev[d], "R2", int'(bo[d]), int'(byte_prev[d]));
      rdy = (cyc % 3) != 2;
      for (int d = 0; d < 3; d++) begin
        if (vld[d]) any = 1;
        if (vld[d] && rdy) begin
          chk(dcv[d] == 1'b0, "R1", int'(dcv[d]), 0);
          if (ngot[d] < 256) got[d][ngot[d]] = bo[d];
          ngot[d]++;
        end
        stall_prev[d] = vld[d] && !rdy;
        byte_prev[d] = bo[d];
      end
      quiet = any ? 0 : quiet + 1;
    end
  end

  task automatic push(input int d, input logic [7:0] b);
    expb[d][nexp[d]] = b;
    nexp[d]++;
  endtask

  function automatic logic [7:0] ctr_default(input int d);
    if (CTR_C[d] != 8'h00) return CTR_C[d];
    return (ROWS_C[d] == 64) ? 8'hCF : 8'h8F;
  endfunction

  task automatic push_init(input int d);
    logic [7:0] m, p;
    m = (ROWS_C[d] == 64) ? 8'h3F : (ROWS_C[d] == 48) ? 8'h2F : 8'h1F;
    p = (ROWS_C[d] == 64 || ROWS_C[d] == 48) ? 8'h12 : 8'h02;
    push(d, 8'hAE); push(d, 8'hD5); push(d, 8'h80); push(d, 8'hA8); push(d, m);
    push(d, 8'hD3); push(d, 8'h00); push(d, 8'h40); push(d, 8'h8D); push(d, 8'h14);
    push(d, 8'h20); push(d, 8'h01); push(d, 8'hA1); push(d, 8'hC8); push(d, 8'hDA);
    push(d, p);     push(d, 8'hD9); push(d, 8'hF1); push(d, 8'hDB); push(d, 8'h40);
    push(d, 8'hA4); push(d, 8'hA6); push(d, 8'h81); push(d, ctr_default(d)); push(d, 8'hAF);
  endtask

  task automatic push_win(input int d);
    push(d, 8'h00); push(d, 8'h10); push(d, 8'h40);
    if (ROWS_C[d] == 48 && COLS_C[d] == 64) begin
      push(d, 8'h21); push(d, 8'h20); push(d, 8'h5F);
      push(d, 8'h22); push(d, 8'h00); push(d, 8'h05);
    end
  endtask

  task automatic push_all_win();
    for (int d = 0; d < 3; d++) push_win(d);
  endtask

  task automatic push_all(input logic [7:0] b);
    for (int d = 0; d < 3; d++) push(d, b);
  endtask

  task automatic pulse(input bit b, input bit u, input bit c, input logic [7:0] v, input bit w);
    blank_req = b; unblank_req = u; contrast_req = c; cval = v; window_req = w;
    @(negedge clk);
    blank_req = 0; unblank_req = 0; contrast_req = 0; window_req = 0;
  endtask

  task automatic wait_quiet();
    repeat (4) @(negedge clk);
    while (quiet < 12) @(negedge clk);
  endtask

  task automatic cmp(input string req);
    for (int d = 0; d < 3; d++) begin
      chk(ngot[d] == nexp[d], req, ngot[d], nexp[d]);
      for (int i = pos[d]; i < nexp[d] && i < ngot[d]; i++)
        chk(got[d][i] == expb[d][i], req, int'(got[d][i]), int'(expb[d][i]));
      pos[d] = nexp[d];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(!vld[d] && bsy[d] && !dcv[d], "R11", {vld[d], bsy[d], dcv[d]}, 3'b010);
    for (int d = 0; d < 3; d++) push_init(d);

    rst_n = 1;
    n = 0;
    while (!vld[0]) begin
      @(negedge clk);
      n++;
    end
    chk(n == HOLD, "R6", n, HOLD);
    chk(vld[1] && vld[2], "R6", {vld[1], vld[2]}, 2'b11);

    // requests during power-up: held, then served blank, contrast, window (R10)
    @(negedge clk);
    pulse(0, 0, 0, 8'h00, 1);
    pulse(0, 0, 1, 8'h55, 0);
    pulse(1, 0, 0, 8'h00, 0);
    while (bsy[0]) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk(ngot[d] == 25, "R4", ngot[d], 25);
      chk(!bsy[d], "R4", int'(bsy[d]), 0);
    end
    wait_quiet();
    for (int d = 0; d < 3; d++) begin
      chk(got[d][4] == expb[d][4], "R3", int'(got[d][4]), int'(expb[d][4]));
      chk(got[d][15] == expb[d][15], "R3", int'(got[d][15]), int'(expb[d][15]));
      chk(got[d][23] == ctr_default(d), "R5", int'(got[d][23]), int'(ctr_default(d)));
    end
    push_all(8'hAE); push_all(8'h81); push_all(8'h55); push_all_win();
    cmp("R10");

    // unblank alone, then blank with unblank in one cycle (R7)
    pulse(0, 1, 0, 8'h00, 0);
    wait_quiet();
    push_all(8'hAF);
    cmp("R7");
    pulse(1, 1, 0, 8'h00, 0);
    wait_quiet();
    push_all(8'hAE);
    cmp("R7");

    // window alone (R9)
    pulse(0, 0, 0, 8'h00, 1);
    wait_quiet();
    push_all_win();
    cmp("R9");

    // requests stacked on a running window: last contrast value, unblank cancels blank
    pulse(0, 0, 0, 8'h00, 1);
    pulse(0, 0, 1, 8'h11, 0);
    pulse(0, 0, 1, 8'h22, 0);
    pulse(1, 0, 0, 8'h00, 0);
    pulse(0, 1, 0, 8'h00, 0);
    wait_quiet();
    push_all_win(); push_all(8'hAF); push_all(8'h81); push_all(8'h22);
    cmp("R8");

    // contrast boundary values (R8)
    pulse(0, 0, 1, 8'h00, 0);
    wait_quiet();
    push_all(8'h81); push_all(8'h00);
    cmp("R8");
    pulse(0, 0, 1, 8'hFF, 0);
    wait_quiet();
    push_all(8'h81); push_all(8'hFF);
    cmp("R8");

    for (int d = 0; d < 3; d++) chk(!bsy[d], "R4", int'(bsy[d]), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule